// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Alarm

The block keeps a free-running count of time in a slow clock domain. A programmable prescaler divides the slow clock, and every time the prescaler wraps the counter advances by one. The counter is compared with an alarm value on every advance, and two sticky status flags record that an advance happened and that the alarm value was reached. With the default divisor of 0x8000 and a 32768 Hz slow clock, the count advances once per second.

Software reaches the block through a plain register port in the system-clock domain. Through that port it can set the divisor and the two interrupt enables, request a restart, write the alarm value, read the live count and read the status flags. Restart and status-clear requests cross into the slow domain as toggles. Each request takes effect on the second slow-clock rising edge after the access. Requests must be spaced at least one slow-clock cycle apart. The live count crosses back through a two-flop synchronizer. Software should read it twice and accept the value only when both reads agree. The interrupt line is the OR of each flag gated by its own enable.

The register port has no back-pressure. An access is a single-cycle strobe. Read data appears on `reg_rdata` on the system-clock cycle after `reg_rd`, and it holds there until the next read.

Top module: `rt_alarm_counter`

## Requirements
- R1: After reset the mode register reads a divisor field of 2^(PRE_W-1) (0x8000 by default) with both enables clear. The alarm register reads all ones over CNT_W bits. The count and status read 0, and `irq` is low.
- R2: After a restart with divisor field P, the count reads floor(j/Pe) once j slow edges have passed beyond the restart edge. Pe is P, or 2^PRE_W when P is 0. Out of reset the divisor 2^(PRE_W-1) applies with no restart.
- R3: A write to mode register (address 0) with bit 31 set clears the count and reloads the prescaler from the new divisor on the second slow rising edge after the write. One edge after the write, the count has not yet been cleared.
- R4: Status bit 0 (tick flag) is set on the slow edge on which the count advances.
- R5: Status bit 1 (alarm flag) is set on the slow edge on which the count changes to a value equal to the alarm register (address 1).
- R6: A read of the status register (address 3) clears both flags on the second slow rising edge after the read. If a flag is set again on that same edge, the set wins.
- R7: `irq` is high exactly when (tick flag AND mode bit 17) OR (alarm flag AND mode bit 16). It is observed in the system domain after synchronization.
- R8: The count wraps from all ones (CNT_W bits) to 0.
- R9: The mode register reads back the divisor in bits [PRE_W-1:0] and the enables in bits 16 and 17. Bit 31 and all other bits read 0. The alarm register reads back its low CNT_W bits. Writing mode without bit 31 does not change the running divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register port |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| slow_clk | input | 1 | Slow timebase clock |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 alarm, 2 count, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 4-bit prescaler and an 8-bit counter. With those widths it sweeps every small divisor, including the zero case that means divide-by-16, and runs the counter through its wrap from 0xFF to 0 within a short run. The bench drives the slow clock edge by edge, so it knows exactly which slow edge a restart or status clear must land on. This lets it test the two-edge delay and the case where a set and a clear land on the same edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    REG_MODE   = 2'd0,
    REG_ALARM  = 2'd1,
    REG_COUNT  = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_ALM_EN  = 16;
  localparam int unsigned BIT_TICK_EN = 17;
  localparam int unsigned BIT_RESTART = 31;

  typedef struct packed {
    logic alarm;
    logic tick;
  } flags_t;
endpackage

// File: rtl/rtc_req_xing.sv
module rtc_req_xing (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic req,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic pulse
);
  logic tgl_q;
  logic s1_q, s2_q;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= tgl_q ^ req;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= tgl_q;
      s2_q <= s1_q;
    end
  end

  // The effect lands on the second destination edge after the request.
  assign pulse = s1_q ^ s2_q;
endmodule

// File: rtl/rtc_sync_vec.sv
module rtc_sync_vec #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core
  import rtc_pkg::*;
#(
  parameter int unsigned PRE_W = 16,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             clr,
  input  logic [PRE_W-1:0] div,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] cnt_q,
  output flags_t           flags_q
);
  localparam logic [PRE_W-1:0] DIV_RST = PRE_W'(1) << (PRE_W - 1);

  logic [PRE_W-1:0] pre_q, div_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             inc, alarm_hit;

  assign inc       = !restart && (pre_q == '0);
  assign cnt_nxt   = restart ? '0 : (inc ? cnt_q + CNT_W'(1) : cnt_q);
  assign alarm_hit = (restart || inc) && (cnt_nxt == alarm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_RST;
      pre_q <= DIV_RST - PRE_W'(1);
    end else if (restart) begin
      div_q <= div;
      pre_q <= div - PRE_W'(1);
    end else if (inc) begin
      pre_q <= div_q - PRE_W'(1);
    end else begin
      pre_q <= pre_q - PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flags_q <= '0;
    end else begin
      cnt_q         <= cnt_nxt;
      flags_q.tick  <= inc       || (flags_q.tick  && !clr);
      flags_q.alarm <= alarm_hit || (flags_q.alarm && !clr);
    end
  end

  a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))));
  a_r4_tick_on_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && cnt_nxt != cnt_q) |=> flags_q.tick);
  a_r6_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc && !restart) |=> (!flags_q.tick && !flags_q.alarm));
  a_r5_alarm_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags_q.alarm) && $stable(alarm)) |-> (cnt_q == alarm));
endmodule

// File: rtl/rt_alarm_counter.sv
module rt_alarm_counter
  import rtc_pkg::*;
#(
  parameter int unsigned PRE_W = 16,  // at most 16
  parameter int unsigned CNT_W = 32   // at most 32
) (
  input  logic        sys_clk,
  input  logic        sys_rst_n,
  input  logic        slow_clk,
  input  logic        slow_rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam logic [PRE_W-1:0] DIV_RST = PRE_W'(1) << (PRE_W - 1);
  localparam int unsigned      REQ_N   = 2;
  localparam int unsigned      FLG_W   = $bits(flags_t);

  reg_sel_e         sel;
  logic [PRE_W-1:0] div_q;
  logic             en_alarm_q, en_tick_q;
  logic [CNT_W-1:0] alarm_q;
  logic [CNT_W-1:0] cnt_slow, cnt_sys;
  flags_t           flags_slow, flags_sys;
  logic [REQ_N-1:0] req_sys, pulse_slow;
  logic [31:0]      rd_mux;
  logic             unused_bits;

  assign sel         = reg_sel_e'(reg_addr);
  assign unused_bits = ^reg_wdata;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      div_q      <= DIV_RST;
      en_alarm_q <= 1'b0;
      en_tick_q  <= 1'b0;
      alarm_q    <= '1;
    end else if (reg_wr) begin
      if (sel == REG_MODE) begin
        div_q      <= reg_wdata[PRE_W-1:0];
        en_alarm_q <= reg_wdata[BIT_ALM_EN];
        en_tick_q  <= reg_wdata[BIT_TICK_EN];
      end
      if (sel == REG_ALARM) alarm_q <= reg_wdata[CNT_W-1:0];
    end
  end

  // index 0: restart, index 1: status clear
  assign req_sys[0] = reg_wr && (sel == REG_MODE) && reg_wdata[BIT_RESTART];
  assign req_sys[1] = reg_rd && (sel == REG_STATUS);

  for (genvar g = 0; g < REQ_N; g++) begin : g_xing
    rtc_req_xing u_xing (
      .src_clk  (sys_clk),
      .src_rst_n(sys_rst_n),
      .req      (req_sys[g]),
      .dst_clk  (slow_clk),
      .dst_rst_n(slow_rst_n),
      .pulse    (pulse_slow[g])
    );
  end

  rtc_slow_core #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_core (
    .clk    (slow_clk),
    .rst_n  (slow_rst_n),
    .restart(pulse_slow[0]),
    .clr    (pulse_slow[1]),
    .div    (div_q),
    .alarm  (alarm_q),
    .cnt_q  (cnt_slow),
    .flags_q(flags_slow)
  );

  rtc_sync_vec #(.W(CNT_W)) u_cnt_sync (
    .clk  (sys_clk),
    .rst_n(sys_rst_n),
    .d    (cnt_slow),
    .q    (cnt_sys)
  );

  rtc_sync_vec #(.W(FLG_W)) u_flag_sync (
    .clk  (sys_clk),
    .rst_n(sys_rst_n),
    .d    (flags_slow),
    .q    (flags_sys)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      REG_MODE: begin
        rd_mux[PRE_W-1:0]   = div_q;
        rd_mux[BIT_ALM_EN]  = en_alarm_q;
        rd_mux[BIT_TICK_EN] = en_tick_q;
      end
      REG_ALARM:  rd_mux[CNT_W-1:0] = alarm_q;
      REG_COUNT:  rd_mux[CNT_W-1:0] = cnt_sys;
      REG_STATUS: rd_mux[FLG_W-1:0] = flags_sys;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq <= (flags_sys.tick && en_tick_q) || (flags_sys.alarm && en_alarm_q);
    end
  end

  a_r7_irq_has_source: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    irq |-> $past(flags_sys != '0));
  a_r7_irq_needs_enable: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    irq |-> $past(en_tick_q || en_alarm_q));
endmodule

// File: tb/test_rt_alarm_counter.sv
module test_rt_alarm_counter;
  localparam int unsigned PRE_W = 4;
  localparam int unsigned CNT_W = 8;

  logic        sys_clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        slow_rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  rt_alarm_counter #(.PRE_W(PRE_W), .CNT_W(CNT_W)) i_rt_alarm_counter (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .slow_clk(slow_clk),
    .slow_rst_n(slow_rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5ns sys_clk = ~sys_clk;

  localparam logic [31:0] RESTART = 32'h8000_0000;
  localparam logic [31:0] EN_ALM  = 32'h0001_0000;
  localparam logic [31:0] EN_TICK = 32'h0002_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge sys_clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge sys_clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge sys_clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge sys_clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic slow_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sys_clk); slow_clk = 1'b1;
      repeat (3) @(negedge sys_clk);
      slow_clk = 1'b0;
      repeat (3) @(negedge sys_clk);
    end
  endtask

  initial begin
    #2ms;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge sys_clk);
    sys_rst_n = 1'b1; slow_rst_n = 1'b1;
    repeat (2) @(negedge sys_clk);

    // R1 reset state
    rd(2'd0, v); check("R1 mode", v, 32'h0000_0008);
    rd(2'd1, v); check("R1 alarm", v, 32'h0000_00FF);
    rd(2'd2, v); check("R1 count", v, 32'h0);
    rd(2'd3, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R9 readback masking; mode write without restart keeps running divisor
    wr(2'd0, 32'h7FFF_FFFF);
    rd(2'd0, v); check("R9 mode readback", v, 32'h0003_000F);
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, v); check("R9 alarm readback", v, 32'h0000_0078);
    wr(2'd1, 32'hFF);
    wr(2'd0, 32'h8);

    // R2 default divisor out of reset, R9 divisor unchanged without restart
    slow_ticks(20);
    rd(2'd2, v); check("R2 reset divisor", v, 32'd2);

    // R2/R3 sweep of divisors, 0 meaning 2^PRE_W
    for (int p = 0; p <= 6; p++) begin
      int pe;
      pe = (p == 0) ? 16 : p;
      wr(2'd0, RESTART | p);
      slow_ticks(1);
      rd(2'd2, v); check("R3 not yet cleared", {31'b0, v != 0}, 32'h1);
      slow_ticks(1);
      rd(2'd2, v); check("R3 cleared on second edge", v, 32'h0);
      for (int j = 1; j <= 2 * pe + 1; j++) begin
        slow_ticks(1);
        rd(2'd2, v); check("R2 count vs divisor", v, j / pe);
      end
    end

    // R4/R6 with divisor 3: advances at j=3,6
    wr(2'd0, RESTART | 32'd3);
    slow_ticks(2);
    slow_ticks(3);
    check("R7 irq off without enables", {31'b0, irq}, 32'h0);
    rd(2'd3, v); check("R4 tick set", v, 32'h1);
    slow_ticks(1);
    rd(2'd3, v); check("R6 not cleared after one edge", v, 32'h1);
    slow_ticks(1);
    rd(2'd3, v); check("R6 cleared after two edges", v, 32'h0);
    slow_ticks(1);
    rd(2'd3, v); check("R6 set wins over clear", v, 32'h1);
    rd(2'd2, v); check("R2 count at j=6", v, 32'd2);

    // R5/R7 alarm at 5 with divisor 1, only alarm enabled
    wr(2'd1, 32'd5);
    wr(2'd0, RESTART | EN_ALM | 32'd1);
    slow_ticks(2);
    slow_ticks(4);
    check("R7 tick alone no irq", {31'b0, irq}, 32'h0);
    rd(2'd3, v); check("R5 no alarm before match", v, 32'h1);
    slow_ticks(1);
    check("R7 irq on alarm", {31'b0, irq}, 32'h1);
    rd(2'd3, v); check("R5 alarm on match", v, 32'h3);
    slow_ticks(1);
    check("R7 irq drops after clear", {31'b0, irq}, 32'h0);
    rd(2'd3, v); check("R6 alarm cleared", v, 32'h1);

    // R7 tick enable
    wr(2'd0, EN_TICK | 32'd1);
    slow_ticks(2);
    check("R7 irq on tick", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'd1);
    slow_ticks(1);
    check("R7 irq off when disabled", {31'b0, irq}, 32'h0);

    // R8 wrap
    wr(2'd1, 32'hFF);
    wr(2'd0, RESTART | 32'd1);
    slow_ticks(2);
    slow_ticks(255);
    rd(2'd2, v); check("R8 at all ones", v, 32'hFF);
    slow_ticks(1);
    rd(2'd2, v); check("R8 wrapped to zero", v, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule